// File: doc/BRIEF.md
# Two-Point ADC Calibration Engine

This block turns a raw 12-bit converter code into a calibrated, scaled reading for one of sixteen channels. Each channel owns a fixed pair of expected voltages and a pair of trim readings. The block also shares one pair of ideal codes, 2064 and 3112, across all channels. Four channels (11, 12, 13 and 15) carry no calibration and pass their raw code through unchanged. All arithmetic is signed 32-bit integer work with a scale factor of 1000. Every division truncates toward zero.

A calibration pass is started with a one-cycle request. The engine then walks the channels in order. For each calibrated channel it computes a gain-error term, a voltage gain and an offset on a single shared serial divider, and stores them in a per-channel parameter file. After that, a raw code presented with a valid strobe while the engine is idle is corrected with the stored offset and gain error, then scaled by the channel gain. The result is returned with a one-cycle done strobe and a flag that marks a correction that went negative.

The trims are parallel inputs, sampled only while calibration runs. Before the first calibration pass every channel behaves as an identity path.

Top module: `adccal_engine`

## Requirements
- R1: After reset, busy, done, mismatch and the result output are all 0.
- R2: A cal_start pulse seen while busy is low raises busy on the next cycle. Busy stays high until every calibrated channel has new parameters, then drops. A cal_start pulse seen while busy is high has no effect.
- R3: For a calibrated channel, the gain error is k = 1000 + (1000*(d2-d1))/(3112-2064). Here d1 is the channel's low trim and d2 its high trim, both signed two's-complement 8-bit fields. Channel c's trim occupies bits [8c+7:8c] of its trim bus. The division truncates toward zero.
- R4: For a calibrated channel, the gain is ((v2-v1)*1000)/1048. The (v1,v2) pairs are:
  - (630,950) for channels 0, 1, 3, 4 and 5
  - (1260,1900) for channel 2
  - (2520,3800) for channels 6 and 7
  - (3150,4750) for channel 8
  - (5670,8550) for channel 9
  - (3465,5225) for channel 10
  - (3645,5225) for channel 14
- R5: For a calibrated channel, the offset is d1*1000 - (k-1000)*2064. The corrected code is (raw*1000 - offset)/k, truncated toward zero.
- R6: The reported result is (corrected*gain)/1000, truncated toward zero.
- R7: A negative corrected code gives a result of 0 with mismatch high. Any other conversion reports mismatch low and a non-negative result.
- R8: Channels 11, 12, 13 and 15 report the raw code unchanged with mismatch low, whatever their trim inputs are.
- R9: Before the first calibration pass completes, every channel reports the raw code unchanged.
- R10: A valid strobe seen while busy is low is accepted, and busy is high on the next cycle. The done strobe lasts one cycle, with busy already low. It carries the result, the mismatch flag and the channel number. A valid strobe seen while busy is high is ignored.
- R11: A trim input that changes after a calibration pass has no effect on conversions until the next pass. That pass uses the new trims.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cal_start_i | input | 1 | Starts a calibration pass when idle |
| trim_lo_i | input | 128 | Low trim per channel, 8 signed bits each |
| trim_hi_i | input | 128 | High trim per channel, 8 signed bits each |
| cv_valid_i | input | 1 | Raw code valid strobe |
| cv_chan_i | input | 4 | Channel of the raw code |
| cv_code_i | input | 12 | Raw converter code |
| busy_o | output | 1 | High during calibration and during each conversion |
| cv_done_o | output | 1 | One-cycle strobe marking a new result |
| cv_result_o | output | 32 | Calibrated, scaled reading |
| cv_mismatch_o | output | 1 | Corrected code was negative; result clamped to 0 |
| cv_chan_o | output | 4 | Channel the result belongs to |

## Verification
The corrected-and-scaled path is tried with low, middle and full-scale codes on several channels, using positive, negative and zero trim differences, so that offset sign and gain error are both exercised. A trim pair of 0 and -2 on the high-gain channel tells truncation toward zero from flooring. It does so in both the gain-error division and the correction division, because a floor would move the result by several counts. A large positive low trim forces the negative clamp. Codes on uncalibrated channels with non-zero trims, codes sent before any calibration, and trims changed after a pass separate the bypass path, the identity reset state and the trim sampling point from the corrected path.

// File: rtl/adccal_pkg.sv
package adccal_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_KGO,
      ST_KWAIT,
      ST_GGO,
      ST_GWAIT,
      ST_WRITE,
      ST_CGO,
      ST_CWAIT,
      ST_SGO,
      ST_SWAIT
   } adccal_st_e;

   // channels that carry no calibration data
   function automatic logic chan_bypass(input int unsigned ch);
      return (ch == 11) || (ch == 12) || (ch == 13) || (ch >= 15);
   endfunction

   function automatic int chan_volt_lo(input int unsigned ch);
      case (ch)
         2:       return 1260;
         6, 7:    return 2520;
         8:       return 3150;
         9:       return 5670;
         10:      return 3465;
         14:      return 3645;
         0, 1, 3, 4, 5: return 630;
         default: return 0;
      endcase
   endfunction

   function automatic int chan_volt_hi(input int unsigned ch);
      case (ch)
         2:       return 1900;
         6, 7:    return 3800;
         8:       return 4750;
         9:       return 8550;
         10, 14:  return 5225;
         0, 1, 3, 4, 5: return 950;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/adccal_div.sv
module adccal_div #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic [W-1:0] num_i,
   input  logic [W-1:0] den_i,
   output logic         done_o,
   output logic [W-1:0] quot_o
);
   localparam int unsigned CW = $clog2(W);

   logic          run_q, neg_q, zero_q, done_q;
   logic [CW-1:0] cnt_q;
   logic [W-1:0]  rem_q, acc_q, den_q, quot_q;
   logic [W-1:0]  num_mag, den_mag;
   logic [W:0]    shifted, trial;
   logic          fits;
   logic [W-1:0]  rem_nxt, acc_nxt;

   assign num_mag = num_i[W-1] ? (~num_i + W'(1)) : num_i;
   assign den_mag = den_i[W-1] ? (~den_i + W'(1)) : den_i;

   // one restoring step per cycle
   assign shifted = {rem_q, acc_q[W-1]};
   assign trial   = shifted - {1'b0, den_q};
   assign fits    = ~trial[W];
   assign rem_nxt = fits ? trial[W-1:0] : shifted[W-1:0];
   assign acc_nxt = {acc_q[W-2:0], fits};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q  <= 1'b0;
         neg_q  <= 1'b0;
         zero_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
         rem_q  <= '0;
         acc_q  <= '0;
         den_q  <= '0;
         quot_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (start_i && !run_q) begin
            run_q  <= 1'b1;
            cnt_q  <= '0;
            rem_q  <= '0;
            acc_q  <= num_mag;
            den_q  <= den_mag;
            neg_q  <= num_i[W-1] ^ den_i[W-1];
            zero_q <= (den_i == '0);
         end else if (run_q) begin
            rem_q <= rem_nxt;
            acc_q <= acc_nxt;
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == CW'(W-1)) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
               if (zero_q)     quot_q <= '0;
               else if (neg_q) quot_q <= ~acc_nxt + W'(1);
               else            quot_q <= acc_nxt;
            end
         end
      end
   end

   assign done_o = done_q;
   assign quot_o = quot_q;
endmodule

// File: rtl/adccal_store.sv
module adccal_store #(
   parameter int unsigned NCH   = 16,
   parameter int unsigned ACC_W = 32,
   parameter int unsigned SCALE = 1000,
   localparam int unsigned CH_W = $clog2(NCH)
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    we_i,
   input  logic [CH_W-1:0]         widx_i,
   input  logic signed [ACC_W-1:0] wk_i,
   input  logic signed [ACC_W-1:0] wg_i,
   input  logic signed [ACC_W-1:0] woff_i,
   input  logic [CH_W-1:0]         ridx_i,
   output logic signed [ACC_W-1:0] rk_o,
   output logic signed [ACC_W-1:0] rg_o,
   output logic signed [ACC_W-1:0] roff_o
);
   localparam logic signed [ACC_W-1:0] UNITY = ACC_W'(SCALE);

   logic signed [ACC_W-1:0] k_a   [NCH];
   logic signed [ACC_W-1:0] g_a   [NCH];
   logic signed [ACC_W-1:0] off_a [NCH];

   // identity parameters out of reset: gain error and gain equal the scale
   for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic signed [ACC_W-1:0] k_q, g_q, off_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            k_q   <= UNITY;
            g_q   <= UNITY;
            off_q <= '0;
         end else if (we_i && (widx_i == CH_W'(c))) begin
            k_q   <= wk_i;
            g_q   <= wg_i;
            off_q <= woff_i;
         end
      end
      assign k_a[c]   = k_q;
      assign g_a[c]   = g_q;
      assign off_a[c] = off_q;
   end

   always_comb begin
      rk_o   = UNITY;
      rg_o   = UNITY;
      roff_o = '0;
      if (32'(ridx_i) < NCH) begin
         rk_o   = k_a[ridx_i];
         rg_o   = g_a[ridx_i];
         roff_o = off_a[ridx_i];
      end
   end
endmodule

// File: rtl/adccal_engine.sv
module adccal_engine
   import adccal_pkg::*;
#(
   parameter int unsigned NCH    = 16,
   parameter int unsigned CODE_W = 12,
   parameter int unsigned TRIM_W = 8,
   parameter int unsigned ACC_W  = 32,
   parameter int unsigned SCALE  = 1000,
   parameter int unsigned X_LO   = 2064,
   parameter int unsigned X_HI   = 3112,
   localparam int unsigned CH_W  = $clog2(NCH)
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    cal_start_i,
   input  logic [NCH*TRIM_W-1:0]   trim_lo_i,
   input  logic [NCH*TRIM_W-1:0]   trim_hi_i,
   input  logic                    cv_valid_i,
   input  logic [CH_W-1:0]         cv_chan_i,
   input  logic [CODE_W-1:0]       cv_code_i,
   output logic                    busy_o,
   output logic                    cv_done_o,
   output logic [ACC_W-1:0]        cv_result_o,
   output logic                    cv_mismatch_o,
   output logic [CH_W-1:0]         cv_chan_o
);
   localparam logic signed [ACC_W-1:0] SC = ACC_W'(SCALE);
   localparam logic signed [ACC_W-1:0] DX = ACC_W'(X_HI - X_LO);
   localparam logic signed [ACC_W-1:0] XL = ACC_W'(X_LO);

   if (X_HI <= X_LO) begin : g_bad_codes
      $error("ideal high code must exceed ideal low code");
   end
   if (TRIM_W >= ACC_W || CODE_W >= ACC_W) begin : g_bad_width
      $error("trim and code widths must be below the accumulator width");
   end
   if (NCH < 2) begin : g_bad_nch
      $error("at least two channels required");
   end

   adccal_st_e st_q;
   logic [CH_W-1:0]         idx_q, chan_q;
   logic [CODE_W-1:0]       code_q;
   logic signed [ACC_W-1:0] k_q, g_q, corr_q;
   logic                    done_q, mm_q;
   logic [ACC_W-1:0]        res_q;
   logic [CH_W-1:0]         chan_out_q;

   // trims of the channel being calibrated, sign extended
   logic [TRIM_W-1:0]       d1_raw, d2_raw;
   logic signed [ACC_W-1:0] d1, d2, vdiff, code_ext;
   logic                    idx_bypass, chan_bp, idx_last;

   assign d1_raw   = trim_lo_i[idx_q*TRIM_W +: TRIM_W];
   assign d2_raw   = trim_hi_i[idx_q*TRIM_W +: TRIM_W];
   assign d1       = {{(ACC_W-TRIM_W){d1_raw[TRIM_W-1]}}, d1_raw};
   assign d2       = {{(ACC_W-TRIM_W){d2_raw[TRIM_W-1]}}, d2_raw};
   assign vdiff    = ACC_W'(chan_volt_hi(32'(idx_q)) - chan_volt_lo(32'(idx_q)));
   assign code_ext = {{(ACC_W-CODE_W){1'b0}}, code_q};
   assign idx_bypass = chan_bypass(32'(idx_q));
   assign chan_bp    = chan_bypass(32'(chan_q));
   assign idx_last   = (idx_q == CH_W'(NCH-1));

   // parameter file
   logic signed [ACC_W-1:0] rd_k, rd_g, rd_off, wr_off;
   logic                    wr_en;

   assign wr_en  = (st_q == ST_WRITE);
   assign wr_off = d1 * SC - (k_q - SC) * XL;

   adccal_store #(
      .NCH   (NCH),
      .ACC_W (ACC_W),
      .SCALE (SCALE)
   ) u_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr_en),
      .widx_i (idx_q),
      .wk_i   (k_q),
      .wg_i   (g_q),
      .woff_i (wr_off),
      .ridx_i (chan_q),
      .rk_o   (rd_k),
      .rg_o   (rd_g),
      .roff_o (rd_off)
   );

   // shared divider and its operand select
   logic             div_start, div_done;
   logic [ACC_W-1:0] div_num, div_den, div_quot;

   always_comb begin
      div_start = 1'b0;
      div_num   = '0;
      div_den   = DX;
      unique case (st_q)
         ST_KGO: begin
            div_start = !idx_bypass;
            div_num   = SC * (d2 - d1);
            div_den   = DX;
         end
         ST_GGO: begin
            div_start = 1'b1;
            div_num   = SC * vdiff;
            div_den   = DX;
         end
         ST_CGO: begin
            div_start = !chan_bp;
            div_num   = code_ext * SC - rd_off;
            div_den   = rd_k;
         end
         ST_SGO: begin
            div_start = !corr_q[ACC_W-1];
            div_num   = corr_q * rd_g;
            div_den   = SC;
         end
         default: ;
      endcase
   end

   adccal_div #(
      .W (ACC_W)
   ) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (div_start),
      .num_i   (div_num),
      .den_i   (div_den),
      .done_o  (div_done),
      .quot_o  (div_quot)
   );

   // sequencer
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q       <= ST_IDLE;
         idx_q      <= '0;
         chan_q     <= '0;
         code_q     <= '0;
         k_q        <= '0;
         g_q        <= '0;
         corr_q     <= '0;
         done_q     <= 1'b0;
         mm_q       <= 1'b0;
         res_q      <= '0;
         chan_out_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (cal_start_i) begin
                  idx_q <= '0;
                  st_q  <= ST_KGO;
               end else if (cv_valid_i) begin
                  chan_q <= cv_chan_i;
                  code_q <= cv_code_i;
                  st_q   <= ST_CGO;
               end
            end
            ST_KGO: begin
               if (!idx_bypass) begin
                  st_q <= ST_KWAIT;
               end else if (idx_last) begin
                  st_q <= ST_IDLE;
               end else begin
                  idx_q <= idx_q + CH_W'(1);
               end
            end
            ST_KWAIT: begin
               if (div_done) begin
                  k_q  <= SC + $signed(div_quot);
                  st_q <= ST_GGO;
               end
            end
            ST_GGO:   st_q <= ST_GWAIT;
            ST_GWAIT: begin
               if (div_done) begin
                  g_q  <= $signed(div_quot);
                  st_q <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (idx_last) begin
                  st_q <= ST_IDLE;
               end else begin
                  idx_q <= idx_q + CH_W'(1);
                  st_q  <= ST_KGO;
               end
            end
            ST_CGO: begin
               if (chan_bp) begin
                  corr_q <= code_ext;
                  st_q   <= ST_SGO;
               end else begin
                  st_q <= ST_CWAIT;
               end
            end
            ST_CWAIT: begin
               if (div_done) begin
                  corr_q <= $signed(div_quot);
                  st_q   <= ST_SGO;
               end
            end
            ST_SGO: begin
               if (corr_q[ACC_W-1]) begin
                  res_q      <= '0;
                  mm_q       <= 1'b1;
                  done_q     <= 1'b1;
                  chan_out_q <= chan_q;
                  st_q       <= ST_IDLE;
               end else begin
                  st_q <= ST_SWAIT;
               end
            end
            ST_SWAIT: begin
               if (div_done) begin
                  res_q      <= div_quot;
                  mm_q       <= 1'b0;
                  done_q     <= 1'b1;
                  chan_out_q <= chan_q;
                  st_q       <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o        = (st_q != ST_IDLE);
   assign cv_done_o     = done_q;
   assign cv_result_o   = res_q;
   assign cv_mismatch_o = mm_q;
   assign cv_chan_o     = chan_out_q;
endmodule

// File: rtl/adccal_chk.sv
module adccal_chk #(
   parameter int unsigned ACC_W = 32
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             cal_start_i,
   input logic             cv_valid_i,
   input logic             busy_o,
   input logic             cv_done_o,
   input logic [ACC_W-1:0] cv_result_o,
   input logic             cv_mismatch_o
);
   // R2
   start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cal_start_i && !busy_o) |=> busy_o);

   // R10
   accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cv_valid_i && !busy_o) |=> busy_o);

   // R10
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cv_done_o |=> !cv_done_o);

   // R10
   done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cv_done_o |-> !busy_o);

   // R10
   result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cv_done_o |-> $stable(cv_result_o));

   // R7
   clamp_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cv_done_o && cv_mismatch_o) |-> (cv_result_o == '0));

   // R7
   nonneg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cv_done_o |-> !cv_result_o[ACC_W-1]);
endmodule

bind adccal_engine adccal_chk #(
   .ACC_W (ACC_W)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .cal_start_i   (cal_start_i),
   .cv_valid_i    (cv_valid_i),
   .busy_o        (busy_o),
   .cv_done_o     (cv_done_o),
   .cv_result_o   (cv_result_o),
   .cv_mismatch_o (cv_mismatch_o)
);

// File: tb/sim_adccal_engine.sv
module sim_adccal_engine;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic         cal_start = 1'b0;
   logic [127:0] tlo = '0, thi = '0;
   logic         valid = 1'b0;
   logic [3:0]   chan = '0;
   logic [11:0]  code = '0;
   logic         busy, done, mm;
   logic [31:0]  result;
   logic [3:0]   chan_out;

   int n_chk = 0;
   int n_bad = 0;

   int lo_t [16];
   int hi_t [16];
   int snap_lo [16];
   int snap_hi [16];
   bit cal_seen = 0;

   adccal_engine u0 (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .cal_start_i   (cal_start),
      .trim_lo_i     (tlo),
      .trim_hi_i     (thi),
      .cv_valid_i    (valid),
      .cv_chan_i     (chan),
      .cv_code_i     (code),
      .busy_o        (busy),
      .cv_done_o     (done),
      .cv_result_o   (result),
      .cv_mismatch_o (mm),
      .cv_chan_o     (chan_out)
   );

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int v_low(int ch);
      case (ch)
         0, 1, 3, 4, 5: return 630;
         2: return 1260;
         6, 7: return 2520;
         8: return 3150;
         9: return 5670;
         10: return 3465;
         14: return 3645;
         default: return 0;
      endcase
   endfunction

   function automatic int v_high(int ch);
      case (ch)
         0, 1, 3, 4, 5: return 950;
         2: return 1900;
         6, 7: return 3800;
         8: return 4750;
         9: return 8550;
         10, 14: return 5225;
         default: return 0;
      endcase
   endfunction

   function automatic bit no_cal(int ch);
      return ch == 11 || ch == 12 || ch == 13 || ch == 15;
   endfunction

   // expected reading from the requirement formulas
   function automatic void model(int ch, int raw, output int res, output bit flag);
      int k, g, off, corr;
      flag = 1'b0;
      if (!cal_seen || no_cal(ch)) begin
         res = raw;
         return;
      end
      k    = 1000 + (1000 * (snap_hi[ch] - snap_lo[ch])) / 1048;
      g    = ((v_high(ch) - v_low(ch)) * 1000) / 1048;
      off  = snap_lo[ch] * 1000 - (k - 1000) * 2064;
      corr = (raw * 1000 - off) / k;
      if (corr < 0) begin
         flag = 1'b1;
         res  = 0;
         return;
      end
      res = (corr * g) / 1000;
   endfunction

   task automatic drive_trims();
      for (int c = 0; c < 16; c++) begin
         tlo[c*8 +: 8] = 8'(lo_t[c]);
         thi[c*8 +: 8] = 8'(hi_t[c]);
      end
   endtask

   task automatic run_conv(int ch, int raw, output int res, output bit flag, output int ch_o);
      int n;
      @(negedge clk);
      valid = 1'b1;
      chan  = 4'(ch);
      code  = 12'(raw);
      @(negedge clk);
      valid = 1'b0;
      check("R10", "busy after accept", int'(busy), 1);
      n = 0;
      while (!done && n < 3000) begin
         @(negedge clk);
         n++;
      end
      check("R10", "done seen", int'(done), 1);
      res  = int'(result);
      flag = mm;
      ch_o = int'(chan_out);
      @(negedge clk);
      check("R10", "done one cycle", int'(done), 0);
   endtask

   task automatic conv_check(string req, int ch, int raw);
      int r, e, co;
      bit f, ef;
      run_conv(ch, raw, r, f, co);
      model(ch, raw, e, ef);
      check(req, $sformatf("result ch%0d code%0d", ch, raw), r, e);
      check(req, $sformatf("mismatch ch%0d code%0d", ch, raw), int'(f), int'(ef));
      check("R10", "channel tag", co, ch);
   endtask

   task automatic run_cal();
      int n;
      @(negedge clk);
      cal_start = 1'b1;
      @(negedge clk);
      cal_start = 1'b0;
      check("R2", "busy after start", int'(busy), 1);
      for (int c = 0; c < 16; c++) begin
         snap_lo[c] = lo_t[c];
         snap_hi[c] = hi_t[c];
      end
      n = 0;
      while (busy && n < 6000) begin
         @(negedge clk);
         n++;
      end
      check("R2", "busy clears after pass", int'(busy), 0);
      cal_seen = 1;
   endtask

   task automatic t_reset();
      check("R1", "busy", int'(busy), 0);
      check("R1", "done", int'(done), 0);
      check("R1", "result", int'(result), 0);
      check("R1", "mismatch", int'(mm), 0);
   endtask

   task automatic t_pre_init();
      conv_check("R9", 0, 1234);
      conv_check("R9", 9, 4095);
      conv_check("R9", 3, 0);
   endtask

   task automatic t_calibrated();
      conv_check("R6", 0, 2500);
      conv_check("R6", 0, 4095);
      conv_check("R5", 2, 2064);
      conv_check("R4", 7, 3112);
      conv_check("R5", 14, 1500);
      conv_check("R4", 10, 3000);
   endtask

   task automatic t_truncation();
      // R3: low trim 0, high trim -2 on the high-gain channel
      conv_check("R3", 9, 3000);
      conv_check("R3", 9, 2);
      conv_check("R3", 9, 1);
   endtask

   task automatic t_clamp();
      conv_check("R7", 3, 50);
      conv_check("R7", 3, 200);
   endtask

   task automatic t_uncal();
      conv_check("R8", 12, 777);
      conv_check("R8", 15, 4095);
      conv_check("R8", 11, 5);
   endtask

   task automatic t_busy_ignore();
      int n, extra, e;
      bit ef;
      @(negedge clk);
      valid = 1'b1;
      chan  = 4'd0;
      code  = 12'd3000;
      @(negedge clk);
      valid = 1'b0;
      repeat (5) @(negedge clk);
      valid     = 1'b1;
      cal_start = 1'b1;
      chan      = 4'd2;
      code      = 12'd100;
      @(negedge clk);
      valid     = 1'b0;
      cal_start = 1'b0;
      n = 0;
      while (!done && n < 3000) begin
         @(negedge clk);
         n++;
      end
      model(0, 3000, e, ef);
      check("R10", "result with ignored strobe", int'(result), e);
      @(negedge clk);
      check("R2", "no pass after ignored start", int'(busy), 0);
      extra = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (done) extra++;
      end
      check("R10", "extra results", extra, 0);
   endtask

   task automatic t_trim_hold();
      lo_t[0] = 60;
      hi_t[0] = -60;
      drive_trims();
      conv_check("R11", 0, 2500);
      run_cal();
      conv_check("R11", 0, 2500);
      conv_check("R11", 12, 900);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < 16; c++) begin
         lo_t[c] = 0;
         hi_t[c] = 0;
      end
      lo_t[0]  = 5;   hi_t[0]  = 12;
      lo_t[2]  = 10;  hi_t[2]  = 20;
      lo_t[3]  = 100; hi_t[3]  = 100;
      lo_t[7]  = -9;  hi_t[7]  = 4;
      lo_t[9]  = 0;   hi_t[9]  = -2;
      lo_t[10] = 20;  hi_t[10] = -30;
      lo_t[12] = 50;  hi_t[12] = -50;
      lo_t[14] = 3;   hi_t[14] = -7;
      drive_trims();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pre_init();
      run_cal();
      t_calibrated();
      t_truncation();
      t_clamp();
      t_uncal();
      t_busy_ignore();
      t_trim_hold();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule